// File: doc/BRIEF.md
# Tabular Q-Value Update Engine

This block keeps a table of Q values, one row per environment state and one column per action, and applies one temporal-difference learning update per accepted step. Every step brings the state the environment moved into, the action chosen for that state and the reward earned by that choice. The block holds the pair from the previous step in registers. From the new state's row it finds the largest value. It then writes a corrected value back into the previous pair's entry: old value plus alpha times (reward plus gamma times row maximum minus old value).

Each action column is a separate bank. A bank has one read port and one write port. All banks are read at the new state's address in the cycle a step is accepted, and only the bank of the previous action is written. The row maximum comes from a registered binary comparator tree. Two pipelined multiplications follow it. Steps enter on a valid/ready handshake. The sender must hold its data while `in_valid` is high and `in_ready` is low. The block drops `in_ready` while an update is in flight and raises it again in the cycle that writes the table, so a new step can be accepted in that same cycle. The write-back is reported on a one-cycle result strobe. That strobe cannot be back-pressured.

Top module: `qlearn_update`

## Requirements
- R1: After reset every table entry is zero, `in_ready` is 1 and `wb_valid` is 0.
- R2: A step is accepted in a cycle where `in_valid` and `in_ready` are both 1. Accepting any step other than the first after reset drops `in_ready` for the next log2(Z)+2 cycles. `in_ready` is 1 again in the cycle that writes the table.
- R3: The first step accepted after reset only records its state, action and reward. It produces no write-back.
- R4: Every later accepted step updates the entry of the previously accepted (state, action) pair, using the previous step's reward and the maximum of the new state's row. All values are signed two's complement with FRAC fractional bits. The result is new = S(q + S(T(alpha·e))), with e = S(r + S(T(gamma·max)) − q). T is an arithmetic right shift of the full product by FRAC bits, which rounds toward minus infinity. alpha and gamma are taken in the cycle of acceptance.
- R5: S saturates to the range −2^(QW−1) to 2^(QW−1)−1 instead of wrapping.
- R6: `wb_valid` is high for exactly one cycle, log2(Z)+4 cycles after the accepting cycle. In that cycle `wb_state`, `wb_action` and `wb_value` give the entry written and its new value.
- R7: When a step is accepted in the cycle the table is written, and its state equals the written state, its row maximum uses the newly written value.
- R8: The row maximum is a signed comparison over all Z entries, so rows that are entirely negative are handled correctly.
- R9: When the same pair is updated on consecutive steps, each update starts from the value the previous update wrote.
- R10: A step offered while `in_ready` is 0 leaves the table and all results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Step offered |
| in_ready | output | 1 | Step can be accepted this cycle |
| in_state | input | log2(N) | State the environment moved into |
| in_action | input | log2(Z) | Action chosen in that state |
| in_reward | input | QW | Reward for that choice, signed fixed point |
| alpha | input | QW | Learning rate, signed fixed point |
| gamma | input | QW | Discount factor, signed fixed point |
| wb_valid | output | 1 | One-cycle strobe: table entry written |
| wb_state | output | log2(N) | State of written entry |
| wb_action | output | log2(Z) | Action of written entry |
| wb_value | output | QW | New value of the entry |

## Verification
The bound checker checks the handshake and write-back timing in every cycle. It confirms that the ready line drops after each updating acceptance and that the result strobe is a single pulse. It also confirms that the strobe lands exactly the pipeline latency after the acceptance that caused it, and that it names the pair recorded one step earlier, even when a new step is accepted during the write cycle. The values themselves can only be judged by the bench's behavioural table model. Those cases are saturation, signed maxima over negative rows, the write-first bypass, back-to-back updates of one entry, and steps ignored while ready is low, and each needs a scenario built to reach it.

// File: rtl/qlu_pkg.sv
package qlu_pkg;

  // Clamp a wide signed value into a w-bit signed range.
  function automatic longint sat_to(input longint x, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  // Fixed-point product, fractional bits dropped toward minus infinity.
  function automatic longint fx_mul(input longint a, input longint b, input int frac);
    return (a * b) >>> frac;
  endfunction

endpackage

// File: rtl/qlu_bank.sv
module qlu_bank #(
  parameter int DEPTH  = 16,
  parameter int QW     = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [QW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [QW-1:0]     rdata
);
  logic [QW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // write-first: a same-cycle write to the read address is forwarded
  assign rdata = (we && (waddr == raddr)) ? wdata : mem[raddr];
endmodule

// File: rtl/qlu_max_tree.sv
module qlu_max_tree #(
  parameter int Z  = 4,
  parameter int QW = 16,
  localparam int L = $clog2(Z)
) (
  input  logic          clk,
  input  logic [Z*QW-1:0] vals,
  output logic [QW-1:0] max_out
);
  genvar l, i;
  for (l = 0; l <= L; l++) begin : g_lvl
    localparam int CNT = Z >> l;
    logic [CNT*QW-1:0] v;
    if (l == 0) begin : g_in
      assign v = vals;
    end else begin : g_cmp
      for (i = 0; i < CNT; i++) begin : g_node
        logic signed [QW-1:0] x0, x1, r;
        assign x0 = g_lvl[l-1].v[(2*i)*QW +: QW];
        assign x1 = g_lvl[l-1].v[(2*i+1)*QW +: QW];
        always_ff @(posedge clk) r <= (x1 > x0) ? x1 : x0;
        assign v[i*QW +: QW] = r;
      end
    end
  end

  assign max_out = g_lvl[L].v;
endmodule

// File: rtl/qlu_update_math.sv
module qlu_update_math
  import qlu_pkg::*;
#(
  parameter int QW   = 16,
  parameter int FRAC = 12
) (
  input  logic                 clk,
  input  logic signed [QW-1:0] maxq,
  input  logic signed [QW-1:0] rew,
  input  logic signed [QW-1:0] qold,
  input  logic signed [QW-1:0] alpha,
  input  logic signed [QW-1:0] gamma,
  output logic signed [QW-1:0] new_q
);
  logic signed [QW-1:0] gm_r;
  logic signed [QW-1:0] err_r;

  // first multiply: discounted future value
  always_ff @(posedge clk)
    gm_r <= QW'(sat_to(fx_mul(longint'(gamma), longint'(maxq), FRAC), QW));

  // temporal-difference error
  always_ff @(posedge clk)
    err_r <= QW'(sat_to(longint'(rew) + longint'(gm_r) - longint'(qold), QW));

  // second multiply and accumulate, presented to the write port
  assign new_q = QW'(sat_to(longint'(qold) +
                            sat_to(fx_mul(longint'(alpha), longint'(err_r), FRAC), QW), QW));
endmodule

// File: rtl/qlearn_update.sv
module qlearn_update #(
  parameter int N    = 16,
  parameter int Z    = 4,
  parameter int QW   = 16,
  parameter int FRAC = 12,
  localparam int SW  = $clog2(N),
  localparam int AW  = $clog2(Z)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SW-1:0]        in_state,
  input  logic [AW-1:0]        in_action,
  input  logic signed [QW-1:0] in_reward,
  input  logic signed [QW-1:0] alpha,
  input  logic signed [QW-1:0] gamma,
  output logic                 wb_valid,
  output logic [SW-1:0]        wb_state,
  output logic [AW-1:0]        wb_action,
  output logic signed [QW-1:0] wb_value
);
  localparam int L       = $clog2(Z);
  localparam int DEPTH   = L + 3;
  localparam int LATENCY = L + 4;

  logic [DEPTH-1:0]      vld;
  logic                  accept, launch, write_now, have_prev, hit;
  logic [Z*QW-1:0]       row_byp, row_r;
  logic [QW-1:0]         maxq;
  logic signed [QW-1:0]  new_q;

  logic [SW-1:0]         cur_s, p_s;
  logic [AW-1:0]         cur_a, p_a;
  logic signed [QW-1:0]  cur_r, cur_q, p_r, p_q, p_alpha, p_gamma;

  assign in_ready  = ~|vld[DEPTH-2:0];
  assign accept    = in_valid && in_ready;
  assign launch    = accept && have_prev;
  assign write_now = vld[DEPTH-1];
  assign hit       = (p_s == cur_s) && (p_a == cur_a);

  // one bank per action, all read at the incoming state
  genvar b;
  for (b = 0; b < Z; b++) begin : g_bank
    qlu_bank #(.DEPTH(N), .QW(QW), .ADDR_W(SW)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (write_now && (p_a == AW'(b))),
      .waddr (p_s),
      .wdata (new_q),
      .raddr (in_state),
      .rdata (row_byp[b*QW +: QW])
    );
  end

  qlu_max_tree #(.Z(Z), .QW(QW)) u_tree (
    .clk     (clk),
    .vals    (row_r),
    .max_out (maxq)
  );

  qlu_update_math #(.QW(QW), .FRAC(FRAC)) u_math (
    .clk   (clk),
    .maxq  (maxq),
    .rew   (p_r),
    .qold  (p_q),
    .alpha (p_alpha),
    .gamma (p_gamma),
    .new_q (new_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      vld <= {vld[DEPTH-2:0], launch};
    end
  end

  // delay registers for the pair being learned
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      row_r     <= '0;
      cur_s     <= '0;
      cur_a     <= '0;
      cur_r     <= '0;
      cur_q     <= '0;
    end else if (accept) begin
      have_prev <= 1'b1;
      row_r     <= row_byp;
      cur_s     <= in_state;
      cur_a     <= in_action;
      cur_r     <= in_reward;
      cur_q     <= row_byp[in_action*QW +: QW];
    end else if (write_now && hit) begin
      cur_q     <= new_q;
    end
  end

  // operands held for the duration of one update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_s     <= '0;
      p_a     <= '0;
      p_r     <= '0;
      p_q     <= '0;
      p_alpha <= '0;
      p_gamma <= '0;
    end else if (launch) begin
      p_s     <= cur_s;
      p_a     <= cur_a;
      p_r     <= cur_r;
      p_q     <= (write_now && hit) ? new_q : cur_q;
      p_alpha <= alpha;
      p_gamma <= gamma;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid  <= 1'b0;
      wb_state  <= '0;
      wb_action <= '0;
      wb_value  <= '0;
    end else begin
      wb_valid <= write_now;
      if (write_now) begin
        wb_state  <= p_s;
        wb_action <= p_a;
        wb_value  <= new_q;
      end
    end
  end
endmodule

// File: rtl/qlu_checker.sv
module qlu_checker #(
  parameter int SW  = 4,
  parameter int AW  = 2,
  parameter int LAT = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [SW-1:0] in_state,
  input logic [AW-1:0] in_action,
  input logic          wb_valid,
  input logic [SW-1:0] wb_state,
  input logic [AW-1:0] wb_action
);
  logic          seen, seen_launch, acc, launch;
  logic [SW-1:0] prev_s, new_s, old_s;
  logic [AW-1:0] prev_a, new_a, old_a;
  logic [7:0]    cnt, cnt_old;

  assign acc    = in_valid && in_ready;
  assign launch = acc && seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0; seen_launch <= 1'b0;
      prev_s <= '0; prev_a <= '0; new_s <= '0; new_a <= '0;
      old_s <= '0; old_a <= '0; cnt <= '0; cnt_old <= '0;
    end else begin
      if (acc) begin
        seen   <= 1'b1;
        prev_s <= in_state;
        prev_a <= in_action;
      end
      if (launch) begin
        seen_launch <= 1'b1;
        new_s   <= prev_s;
        new_a   <= prev_a;
        old_s   <= new_s;
        old_a   <= new_a;
        cnt     <= 8'd1;
        cnt_old <= (cnt == 8'hff) ? cnt : cnt + 8'd1;
      end else if (cnt != 8'd0 && cnt != 8'hff) begin
        cnt <= cnt + 8'd1;
      end
    end
  end

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ((cnt == 8'(LAT)) || (cnt == 8'd1 && cnt_old == 8'(LAT))));

  a_r4_wb_pair: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ((cnt == 8'(LAT)) ? (wb_state == new_s && wb_action == new_a)
                                   : (wb_state == old_s && wb_action == old_a)));

  a_r6_wb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  a_r2_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !in_ready);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> seen_launch);
endmodule

bind qlearn_update qlu_checker #(.SW(SW), .AW(AW), .LAT(LATENCY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_state  (in_state),
  .in_action (in_action),
  .wb_valid  (wb_valid),
  .wb_state  (wb_state),
  .wb_action (wb_action)
);

// File: tb/qlearn_update_bench.sv
module qlearn_update_bench;
  localparam int N = 16, Z = 4, QW = 16, FRAC = 12;
  localparam int SW = $clog2(N), AW = $clog2(Z), L = $clog2(Z);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n, in_valid, in_ready, wb_valid;
  logic [SW-1:0]        in_state, wb_state;
  logic [AW-1:0]        in_action, wb_action;
  logic signed [QW-1:0] in_reward, alpha, gamma, wb_value;

  qlearn_update #(.N(N), .Z(Z), .QW(QW), .FRAC(FRAC)) u_qlearn_update (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_state(in_state), .in_action(in_action), .in_reward(in_reward),
    .alpha(alpha), .gamma(gamma), .wb_valid(wb_valid), .wb_state(wb_state),
    .wb_action(wb_action), .wb_value(wb_value));

  int    checks = 0, errors = 0;
  string scen = "R1";
  bit    chk_on = 1'b0;

  // behavioural model state
  int tbl [N][Z];
  int rem = 0;
  bit exp_ready = 1'b1, exp_wbv = 1'b0, hp = 1'b0;
  int exp_ws, exp_wa, exp_wv, pend_s, pend_a, pend_v, ps, pa, pr;

  function automatic int satq(input longint x);
    longint hi = (longint'(1) <<< (QW-1)) - 1;
    longint lo = -(longint'(1) <<< (QW-1));
    if (x > hi) return int'(hi);
    if (x < lo) return int'(lo);
    return int'(x);
  endfunction

  function automatic longint fmul(input longint a, input longint b);
    return (a * b) >>> FRAC;
  endfunction

  always @(negedge clk) begin
    if (chk_on) begin
      bit wnow;
      checks++;
      if (in_ready !== exp_ready) begin
        errors++;
        $display("FAIL R2 (%s) in_ready actual %0b expected %0b", scen, in_ready, exp_ready);
      end
      checks++;
      if (wb_valid !== exp_wbv) begin
        errors++;
        $display("FAIL R6 (%s) wb_valid actual %0b expected %0b", scen, wb_valid, exp_wbv);
      end
      if (exp_wbv && wb_valid) begin
        checks++;
        if (int'(wb_state) != exp_ws || int'(wb_action) != exp_wa || int'(wb_value) != exp_wv) begin
          errors++;
          $display("FAIL %s write-back actual s%0d a%0d v%0d expected s%0d a%0d v%0d",
                   scen, wb_state, wb_action, wb_value, exp_ws, exp_wa, exp_wv);
        end
      end
      // advance the model across the coming edge
      wnow = (rem == 1);
      if (wnow) begin
        tbl[pend_s][pend_a] = pend_v;
        exp_ws = pend_s; exp_wa = pend_a; exp_wv = pend_v;
      end
      exp_wbv = wnow;
      if (in_valid && exp_ready) begin
        if (hp) begin
          int m, gm, e, q;
          m = tbl[in_state][0];
          for (int k = 1; k < Z; k++) if (tbl[in_state][k] > m) m = tbl[in_state][k];
          q  = tbl[ps][pa];
          gm = satq(fmul(gamma, m));
          e  = satq(longint'(pr) + gm - q);
          pend_v = satq(longint'(q) + satq(fmul(alpha, e)));
          pend_s = ps; pend_a = pa;
          rem = L + 3;
        end else if (rem > 0) rem--;
        hp = 1'b1; ps = int'(in_state); pa = int'(in_action); pr = int'(in_reward);
      end else if (rem > 0) rem--;
      exp_ready = (rem <= 1);
    end
  end

  task automatic step(input int s, input int a, input int r);
    @(posedge clk); #1;
    in_valid = 1'b1; in_state = SW'(s); in_action = AW'(a); in_reward = QW'(r);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic junk(input int n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1;
      in_state = SW'($urandom_range(N-1, 0)); in_action = AW'($urandom_range(Z-1, 0));
      in_reward = QW'($urandom_range(30000, 0));
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run hung");
    finish_run();
  end

  initial begin
    for (int s = 0; s < N; s++) for (int a = 0; a < Z; a++) tbl[s][a] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_state = '0; in_action = '0; in_reward = '0;
    alpha = 16'sd2048; gamma = 16'sd3072;
    repeat (5) @(posedge clk); #1;
    rst_n = 1'b1; chk_on = 1'b1;
    // R1: idle outputs and zero table seen through later updates
    scen = "R1"; idle(4);
    // R3: first step records only
    scen = "R3"; step(3, 1, 400); idle(12);
    // R4: ordinary learning steps, spaced and back-to-back
    scen = "R4";
    for (int k = 0; k < 24; k++) begin
      step($urandom_range(N-1, 0), $urandom_range(Z-1, 0), int'($urandom_range(16000, 0)) - 8000);
      if (k % 3 == 0) idle(k % 5);
    end
    alpha = 16'sd3500; gamma = 16'sd4000;
    for (int k = 0; k < 12; k++) step($urandom_range(3, 0), $urandom_range(Z-1, 0), 3000 - 500 * k);
    // R8: all-negative rows around states 5 and 6
    scen = "R8";
    for (int k = 0; k < 16; k++) step(5 + (k % 2), k % Z, -9000 - 100 * k);
    idle(8);
    // R9: one pair hammered back-to-back
    scen = "R9";
    for (int k = 0; k < 8; k++) step(2, 0, 1500 * k - 4000);
    // R7: accept in the write cycle at the written state
    scen = "R7";
    step(7, 1, 6000); step(7, 2, 5000); step(7, 3, -2000); step(7, 0, 7000); step(8, 1, 100);
    idle(10);
    // R10: steps offered while not ready
    scen = "R10";
    for (int k = 0; k < 6; k++) begin
      step(9 + k % 3, k % Z, 2000 + 300 * k);
      junk(L + 1);
    end
    idle(10);
    // R5: saturation both ways
    scen = "R5";
    alpha = 16'sh7fff; gamma = 16'sh7fff;
    for (int k = 0; k < 6; k++) step(12, 1, 32767);
    for (int k = 0; k < 6; k++) step(12, 1, -32768);
    step(13, 2, -32768); step(12, 1, 0);
    idle(12);
    finish_run();
  end
endmodule